// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM that never needs an idle cycle between a read and a write. Every command is sampled on the rising clock edge. The write data for a write command arrives on a later edge, so a read can be issued on the very next clock after a write.

A static mode input picks one of two timings. In flow-through mode, read data appears in the cycle after the command and write data is taken one edge later. In pipelined mode, an output register adds one cycle to reads, and write data is taken two edges after the command. A read may target a word whose write data has not yet arrived. In that case the model combines the late bytes with the stored word, so the read always returns the most recent value.

Bursts of four beats are stepped with an advance command, in linear or interleaved order. Three chip enables, per-byte write enables, an asynchronous output enable and an asynchronous sleep input complete the interface.

Top module: `turnless_sram`

## Requirements
- R1: On a rising edge where neither sleep nor advance is high, a new command is accepted only when cs_a, cs_b and cs_c are all high. Otherwise the edge is a deselect, it ends any burst, and rdata_oe stays low in flow-through mode.
- R2: In flow-through mode (pipe_mode=0), read data for a read accepted on edge k is driven with rdata_oe high between edges k and k+1.
- R3: In pipelined mode (pipe_mode=1), read data for a read accepted on edge k is driven between edges k+1 and k+2.
- R4: The data of a write accepted on edge k is sampled from wdata on edge k+1 in flow-through mode and on edge k+2 in pipelined mode. A write never drives rdata.
- R5: A read accepted on the edge directly after a write to the same address returns the new data in both modes, with no idle cycle in between.
- R6: byte_en[i] selects bits [9i+8:9i] of a write. Bytes whose enable is low keep their stored value, including when a read picks up a pending write.
- R7: With cmd_adv high on an edge and a burst open, the 2-bit beat count increments and the same operation repeats. The low two address bits become base+count modulo 4 when burst_ilv=0, and base XOR count when burst_ilv=1. The upper bits are unchanged. An advance with no burst open does nothing.
- R8: When oe is low, rdata_oe is low at once, whatever reads are in flight.
- R9: While sleep is high, no command or advance is accepted and rdata_oe is low. A write issued while asleep leaves the array unchanged.
- R10: Reset leaves rdata_oe low and every word of the array at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| burst_ilv | input | 1 | Static: 1 interleaved, 0 linear burst order |
| cs_a | input | 1 | Chip enable, active high |
| cs_b | input | 1 | Chip enable, active high |
| cs_c | input | 1 | Chip enable, active high |
| sleep | input | 1 | Asynchronous power-down request |
| oe | input | 1 | Asynchronous output enable |
| cmd_adv | input | 1 | Continue the current burst |
| cmd_wr | input | 1 | 1 write, 0 read for a new command |
| addr | input | ADDR_W | Word address of a new command |
| byte_en | input | BYTES | Byte write enables, sampled with the command |
| wdata | input | BYTES*BYTE_W | Late write data |
| rdata | output | BYTES*BYTE_W | Read data |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
The assertions assume that pipe_mode and burst_ilv stay constant between resets, and that oe and sleep, although asynchronous, change only away from the clock edge, so each edge sees one settled value. The bench changes the two mode pins only while reset is held. It drives every input shortly after a rising edge and samples outputs on the falling edge. It feeds late write data from a slot schedule that places each word exactly on its capture edge, and puts random values on wdata in all other cycles. This lets mistimed capture show up as wrong read data.

// File: rtl/turnless_sram.sv
module turnless_sram #(
  parameter int ADDR_W = 5,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9,
  localparam int DW    = BYTES * BYTE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              burst_ilv,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              cs_c,
  input  logic              sleep,
  input  logic              oe,
  input  logic              cmd_adv,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byte_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rdata_oe
);

  logic [DW-1:0] mem [DEPTH];

  logic              b_live, b_wr;
  logic [1:0]        b_cnt;
  logic [ADDR_W-1:0] b_base;

  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [BYTES-1:0]  s1_be;
  logic              s2_vld;
  logic [ADDR_W-1:0] s2_addr;
  logic [BYTES-1:0]  s2_be;

  logic [DW-1:0]     q_reg;
  logic              q_vld;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [BYTES-1:0] en);
    logic [DW-1:0] r;
    r = old_w;
    for (int b = 0; b < BYTES; b++)
      if (en[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [1:0] cnt,
                                                  input logic ilv);
    logic [ADDR_W-1:0] r;
    r = base;
    r[1:0] = ilv ? (base[1:0] ^ cnt) : (base[1:0] + cnt);
    return r;
  endfunction

  wire              selected = cs_a & cs_b & cs_c;
  wire              adv_go   = ~sleep & cmd_adv & b_live;
  wire              new_go   = ~sleep & ~cmd_adv & selected;
  wire [1:0]        cnt_nx   = b_cnt + 2'd1;
  wire              acc_vld  = adv_go | new_go;
  wire              acc_wr   = adv_go ? b_wr : cmd_wr;
  wire [ADDR_W-1:0] acc_addr = adv_go ? beat_addr(b_base, cnt_nx, burst_ilv) : addr;

  wire              cm_vld  = pipe_mode ? s2_vld : (s1_vld & s1_wr);
  wire [ADDR_W-1:0] cm_addr = pipe_mode ? s2_addr : s1_addr;
  wire [BYTES-1:0]  cm_be   = pipe_mode ? s2_be : s1_be;

  wire              fwd_hit = pipe_mode & s2_vld & (s2_addr == s1_addr);
  wire [DW-1:0]     rd_word = mem[s1_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_live <= 1'b0;
      b_wr   <= 1'b0;
      b_cnt  <= '0;
      b_base <= '0;
    end else if (!sleep) begin
      if (adv_go) begin
        b_cnt <= cnt_nx;
      end else if (new_go) begin
        b_live <= 1'b1;
        b_wr   <= cmd_wr;
        b_cnt  <= '0;
        b_base <= addr;
      end else begin
        b_live <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_vld  <= 1'b0;
      s2_addr <= '0;
      s2_be   <= '0;
      q_reg   <= '0;
      q_vld   <= 1'b0;
    end else begin
      s1_vld  <= acc_vld;
      s1_wr   <= acc_wr;
      s1_addr <= acc_addr;
      s1_be   <= byte_en;
      s2_vld  <= s1_vld & s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      q_reg   <= merge(rd_word, wdata, fwd_hit ? s2_be : '0);
      q_vld   <= s1_vld & ~s1_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cm_vld) begin
      mem[cm_addr] <= merge(mem[cm_addr], wdata, cm_be);
    end
  end

  wire rd_live = pipe_mode ? q_vld : (s1_vld & ~s1_wr);

  assign rdata    = pipe_mode ? q_reg : rd_word;
  assign rdata_oe = rd_live & oe & ~sleep;

endmodule

// File: rtl/turnless_sram_chk.sv
module turnless_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic pipe_mode,
  input logic cs_a,
  input logic cs_b,
  input logic cs_c,
  input logic sleep,
  input logic oe,
  input logic cmd_adv,
  input logic cmd_wr,
  input logic rdata_oe
);

  wire fresh = !sleep && !cmd_adv;
  wire sel3  = cs_a && cs_b && cs_c;

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rdata_oe);

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_oe);

  assert_flow_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && fresh && sel3 && !cmd_wr) |=> (rdata_oe || !oe || sleep));

  assert_pipe_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && fresh && sel3 && !cmd_wr) |=> ##1 (rdata_oe || !oe || sleep));

  assert_write_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && fresh && sel3 && cmd_wr) |=> !rdata_oe);

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && fresh && !sel3) |=> !rdata_oe);

endmodule

bind turnless_sram turnless_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
  .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c), .sleep(sleep), .oe(oe),
  .cmd_adv(cmd_adv), .cmd_wr(cmd_wr), .rdata_oe(rdata_oe)
);

// File: tb/turnless_sram_test.sv
module turnless_sram_test;
  localparam int AW = 5;
  localparam int BY = 2;
  localparam int BW = 9;
  localparam int DW = BY * BW;

  logic clk = 0, rst_n = 0;
  logic pipe_m = 0, ilv_m = 0;
  logic cs_a = 0, cs_b = 1, cs_c = 1, sleep = 0, oe = 1;
  logic cmd_adv = 0, cmd_wr = 0;
  logic [AW-1:0] addr = '0;
  logic [BY-1:0] byte_en = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  always #5 clk = ~clk;

  turnless_sram #(.ADDR_W(AW), .BYTES(BY), .BYTE_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_m), .burst_ilv(ilv_m),
    .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c), .sleep(sleep), .oe(oe),
    .cmd_adv(cmd_adv), .cmd_wr(cmd_wr), .addr(addr), .byte_en(byte_en),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

  int checks = 0, fails = 0, cyc = 0;
  bit mon_on = 0, done = 0;

  logic [DW-1:0] refm [1<<AW];
  logic [DW-1:0] wd_slot [8];
  bit            wd_ok [8];
  int            q_due [$];
  logic [DW-1:0] q_val [$];
  string         q_tag [$];

  bit b_live, b_wr;
  logic [1:0] b_cnt;
  logic [AW-1:0] b_base;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [AW-1:0] eff(input logic [AW-1:0] base, input logic [1:0] cnt);
    logic [AW-1:0] r;
    r = base;
    r[1:0] = ilv_m ? (base[1:0] ^ cnt) : (base[1:0] + cnt);
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        int due; logic [DW-1:0] v; string t; bit eo;
        due = q_due.pop_front(); v = q_val.pop_front(); t = q_tag.pop_front();
        eo = oe && !sleep;
        chk(rdata_oe === eo, t, {{(DW-1){1'b0}}, rdata_oe}, {{(DW-1){1'b0}}, eo});
        if (eo) chk(rdata === v, t, rdata, v);
      end else begin
        chk(rdata_oe === 1'b0, "R1", {{(DW-1){1'b0}}, rdata_oe}, '0);
      end
    end
  end

  task automatic step(input bit adv, input bit wr, input bit sel, input logic [AW-1:0] a,
                      input logic [BY-1:0] be, input logic [DW-1:0] d, input string tag);
    int issue, slot;
    bit go, opw;
    logic [AW-1:0] ea;
    @(posedge clk); #1;
    issue = cyc + 1;
    slot = (cyc + 1) % 8;
    cmd_adv = adv; cmd_wr = wr; cs_a = sel; cs_b = 1; cs_c = 1;
    addr = a; byte_en = be;
    wdata = wd_ok[slot] ? wd_slot[slot] : DW'($urandom);
    wd_ok[slot] = 0;
    go = 0; opw = 0; ea = a;
    if (!sleep) begin
      if (adv) begin
        if (b_live) begin b_cnt = b_cnt + 2'd1; ea = eff(b_base, b_cnt); opw = b_wr; go = 1; end
      end else if (sel) begin
        b_base = a; b_cnt = 0; b_wr = wr; b_live = 1; ea = a; opw = wr; go = 1;
      end else b_live = 0;
    end
    if (go) begin
      if (opw) begin
        for (int b = 0; b < BY; b++)
          if (be[b]) refm[ea][b*BW +: BW] = d[b*BW +: BW];
        wd_slot[(issue + (pipe_m ? 2 : 1)) % 8] = d;
        wd_ok[(issue + (pipe_m ? 2 : 1)) % 8] = 1;
      end else begin
        q_due.push_back(issue + (pipe_m ? 1 : 0));
        q_val.push_back(refm[ea]);
        q_tag.push_back(tag);
      end
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(0, 0, 1, a, '0, '0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [BY-1:0] be, input logic [DW-1:0] d);
    step(0, 1, 1, a, be, d, "R4");
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, '0, "R1");
  endtask

  task automatic run_mode(input bit pm, input bit il);
    mon_on = 0;
    @(posedge clk); #1;
    rst_n = 0; pipe_m = pm; ilv_m = il; cs_a = 0; cmd_adv = 0; oe = 1; sleep = 0;
    for (int i = 0; i < (1<<AW); i++) refm[i] = '0;
    for (int i = 0; i < 8; i++) wd_ok[i] = 0;
    b_live = 0; b_cnt = 0; b_wr = 0; b_base = '0;
    @(negedge clk);
    chk(rdata_oe === 1'b0, "R10", {{(DW-1){1'b0}}, rdata_oe}, '0);
    @(posedge clk); #1; rst_n = 1;
    mon_on = 1;
    rd(5'd3, "R10");
    // back-to-back write then read
    wr(5'd1, 2'b11, 18'h2A5A5);
    rd(5'd1, "R5");
    wr(5'd2, 2'b01, 18'h3FFFF);
    rd(5'd2, "R6");
    wr(5'd2, 2'b10, 18'h15555);
    rd(5'd2, "R6");
    // alternating read/write/read
    rd(5'd1, "R2"); wr(5'd4, 2'b11, 18'h01234); rd(5'd4, "R5");
    rd(5'd1, pm ? "R3" : "R2"); idle(1); rd(5'd2, pm ? "R3" : "R2");
    // burst write then burst read, base low bits 2
    wr(5'd6, 2'b11, 18'h10001);
    for (int k = 1; k < 4; k++) step(1, 0, 0, '0, 2'b11, DW'(18'h10001 + k), "R7");
    idle(1);
    step(0, 0, 1, 5'd6, '0, '0, "R7");
    for (int k = 1; k < 4; k++) step(1, 0, 0, '0, '0, '0, "R7");
    rd(5'd4, "R7"); rd(5'd5, "R7"); rd(5'd6, "R7"); rd(5'd7, "R7");
    // advance after deselect does nothing
    idle(1);
    step(1, 1, 0, '0, 2'b11, 18'h3ABCD, "R7");
    idle(3);
    rd(5'd7, "R7");
    // output enable low over a due read
    rd(5'd1, "R8");
    if (!pm) begin @(posedge clk); #1; end
    oe = 0;
    idle(2); oe = 1;
    // sleep blocks a write and a read
    sleep = 1;
    wr(5'd9, 2'b11, 18'h22222);
    rd(5'd9, "R9");
    idle(2);
    sleep = 0;
    idle(2);
    rd(5'd9, "R9");
    // random traffic
    for (int i = 0; i < 250; i++) begin
      int k;
      k = $urandom % 8;
      if (k < 3) rd(AW'($urandom % 8), pm ? "R3" : "R2");
      else if (k < 6) wr(AW'($urandom % 8), BY'($urandom), DW'($urandom));
      else if (k == 6) step(1, 0, 0, '0, BY'($urandom), DW'($urandom), "R7");
      else idle(1);
    end
    idle(4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    run_mode(0, 0);
    run_mode(1, 0);
    run_mode(0, 1);
    run_mode(1, 1);
    mon_on = 0;
    if (q_due.size() != 0) chk(0, "R2", DW'(q_due.size()), '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule